// File: doc/BRIEF.md
# Mid-Bit Sampling Serial Receiver

This block takes one asynchronous serial line and recovers bytes sent as frames of one low start bit, eight data bits least significant first, and one high stop bit. The line is brought into the clock domain through a two-flop synchronizer. A falling edge seen while idle restarts an internal bit timer so that every later sample falls in the middle of a bit. The start bit is sampled again at its middle before any data is taken.

The timing reference is a receive tick supplied from outside at a fixed multiple of the bit rate (the oversampling ratio). Only cycles with the tick high advance the bit timer, so one source can serve several receivers at different rates. A good frame loads the output byte and raises a one-cycle ready pulse. A start bit that has gone high again by mid-bit, or a stop bit sampled low, raises a one-cycle error pulse instead. A parity stage can be switched on by parameter and is off by default.

Top module: `mid_uart_rx`

## Requirements
- R1: While reset is asserted and after it is released, `rx_ready_o` and `rx_error_o` are 0 and `rx_data_o` is 0x00.
- R2: A frame starts only on a high-to-low transition of the synchronized line. If the line stays low, including after a failed frame, it starts no frame and produces no pulse. A later rise with no fall also starts nothing.
- R3: The falling edge realigns the bit timer so that the start bit is sampled OVS/2 ticks later. If the line is high at that sample, the frame is dropped with a one-cycle `rx_error_o` pulse and no ready pulse.
- R4: The eight data bits are sampled at mid-bit, every OVS ticks after the start sample. The first bit received lands in `rx_data_o[0]` and the last in `rx_data_o[7]`.
- R5: A stop bit sampled high raises `rx_ready_o` for exactly one cycle with the received byte on `rx_data_o`. `rx_ready_o` and `rx_error_o` are never high together.
- R6: A stop bit sampled low raises `rx_error_o` for exactly one cycle, gives no ready pulse and leaves `rx_data_o` unchanged.
- R7: `rx_data_o` changes only in the cycle that `rx_ready_o` is high. It holds the last good byte through later frames, bad frames and idle time.
- R8: `os_tick_i` acts as a clock enable for bit timing. With ticks on every other clock, frames whose bit period is OVS ticks (2*OVS clocks) are still received correctly.
- R9: Frames sent back to back, with a new start bit directly after the stop bit, are each received with one ready pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_i | input | 1 | Serial line, idles high, asynchronous to clk |
| os_tick_i | input | 1 | Receive tick at OVS times the bit rate |
| rx_data_o | output | DATA_W | Last good received byte |
| rx_ready_o | output | 1 | One-cycle pulse when a good frame ends |
| rx_error_o | output | 1 | One-cycle pulse on a bad start or stop bit |

## Verification
The bench builds the receiver with OVS=8, eight data bits and parity off. This keeps a bit to 8 or 16 clocks, so every one of the 256 byte values can be sent as a full frame within a short run. The small ratio also makes the mid-bit margin small enough that a start glitch of two clocks, a held-low stop bit and zero-gap frame trains all hit the edge cases of the realign and sample logic. The tick rate is switched from every clock to every other clock to show that only ticks, not clocks, set the sample points.

// File: rtl/mrx_pkg.sv
package mrx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;
endpackage

// File: rtl/mrx_rst_sync.sv
module mrx_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stg_q <= 2'b00;
    else         stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_n_o = stg_q[1];
endmodule

// File: rtl/mrx_line_sync.sv
// Brings the serial line into the clock domain and flags a high-to-low step.
module mrx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_i,
  output logic line_o,
  output logic fall_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      prev_q <= 1'b1;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], rx_i};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign line_o = sh_q[STAGES-1];
  assign fall_o = prev_q & ~sh_q[STAGES-1];
endmodule

// File: rtl/mrx_bit_timer.sv
// Counts receive ticks. A realign request loads the counter so that the
// next strobe arrives half a bit later. After that a strobe comes every OVS ticks.
module mrx_bit_timer #(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic realign_i,
  output logic mid_o
);
  localparam int CW = (OVS > 2) ? $clog2(OVS) : 1;
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);
  localparam logic [CW-1:0] LOAD = CW'(OVS - OVS / 2);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (realign_i)   cnt_d = LOAD;
    else if (tick_i) cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign mid_o = tick_i & ~realign_i & (cnt_q == LAST);
endmodule

// File: rtl/mrx_frame_fsm.sv
// Frame sequencer: start confirmation, data shift, optional parity, stop test.
module mrx_frame_fsm
  import mrx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter bit PARITY_EN  = 1'b0,
  parameter bit PARITY_ODD = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_i,
  input  logic              fall_i,
  input  logic              mid_i,
  output logic              realign_o,
  output rx_state_e         state_o,
  output logic [DATA_W-1:0] data_o,
  output logic              ready_o,
  output logic              error_o
);
  localparam int BW = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [BW-1:0] LASTBIT = BW'(DATA_W - 1);

  rx_state_e         state_q, state_d;
  logic [BW-1:0]     bit_q, bit_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [DATA_W-1:0] dat_q, dat_d;
  logic              par_q, par_d;
  logic              rdy_q, rdy_d;
  logic              err_q, err_d;
  logic              par_bad;

  assign par_bad = PARITY_EN ? par_q : 1'b0;

  always_comb begin
    state_d   = state_q;
    bit_d     = bit_q;
    sh_d      = sh_q;
    dat_d     = dat_q;
    par_d     = par_q;
    rdy_d     = 1'b0;
    err_d     = 1'b0;
    realign_o = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (fall_i) begin
          realign_o = 1'b1;
          state_d   = ST_START;
        end
      end
      ST_START: begin
        if (mid_i) begin
          if (!line_i) begin
            state_d = ST_DATA;
            bit_d   = '0;
            par_d   = PARITY_ODD;
          end else begin
            state_d = ST_IDLE;
            err_d   = 1'b1;
          end
        end
      end
      ST_DATA: begin
        if (mid_i) begin
          sh_d  = {line_i, sh_q[DATA_W-1:1]};
          par_d = par_q ^ line_i;
          if (bit_q == LASTBIT) state_d = PARITY_EN ? ST_PAR : ST_STOP;
          else                  bit_d   = bit_q + 1'b1;
        end
      end
      ST_PAR: begin
        if (mid_i) begin
          par_d   = par_q ^ line_i;
          state_d = ST_STOP;
        end
      end
      ST_STOP: begin
        if (mid_i) begin
          state_d = ST_IDLE;
          if (line_i && !par_bad) begin
            rdy_d = 1'b1;
            dat_d = sh_q;
          end else begin
            err_d = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      sh_q    <= '0;
      dat_q   <= '0;
      par_q   <= 1'b0;
      rdy_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      dat_q   <= dat_d;
      par_q   <= par_d;
      rdy_q   <= rdy_d;
      err_q   <= err_d;
    end
  end

  assign state_o = state_q;
  assign data_o  = dat_q;
  assign ready_o = rdy_q;
  assign error_o = err_q;
endmodule

// File: rtl/mid_uart_rx.sv
module mid_uart_rx
  import mrx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVS        = 16,
  parameter bit PARITY_EN  = 1'b0,
  parameter bit PARITY_ODD = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_i,
  input  logic              os_tick_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_ready_o,
  output logic              rx_error_o
);
  logic      rst_sync_n;
  logic      line_s;
  logic      fall_s;
  logic      mid_stb;
  logic      realign;
  rx_state_e fsm_state;

  mrx_rst_sync i_rst_sync (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  mrx_line_sync #(.STAGES(2)) i_line_sync (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .rx_i   (rx_i),
    .line_o (line_s),
    .fall_o (fall_s)
  );

  mrx_bit_timer #(.OVS(OVS)) i_bit_timer (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .tick_i    (os_tick_i),
    .realign_i (realign),
    .mid_o     (mid_stb)
  );

  mrx_frame_fsm #(
    .DATA_W     (DATA_W),
    .PARITY_EN  (PARITY_EN),
    .PARITY_ODD (PARITY_ODD)
  ) i_frame_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .line_i    (line_s),
    .fall_i    (fall_s),
    .mid_i     (mid_stb),
    .realign_o (realign),
    .state_o   (fsm_state),
    .data_o    (rx_data_o),
    .ready_o   (rx_ready_o),
    .error_o   (rx_error_o)
  );
endmodule

// File: rtl/mid_uart_rx_chk.sv
module mid_uart_rx_chk
  import mrx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              line,
  input logic              mid,
  input rx_state_e         state,
  input logic [DATA_W-1:0] data,
  input logic              rdy,
  input logic              err
);
  p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n) !(rdy && err));
  p_rdy_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n) rdy |=> !rdy);
  p_err_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n) err |=> !err);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n) !rdy |-> $stable(data));
  p_rdy_stop_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy) |-> $past(line) && $past(mid));
  p_err_on_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(mid));
  p_idle_after_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy || err) |-> state == ST_IDLE);
endmodule

bind mid_uart_rx mid_uart_rx_chk #(.DATA_W(DATA_W)) i_chk (
  .clk   (clk),
  .rst_n (rst_sync_n),
  .line  (line_s),
  .mid   (mid_stb),
  .state (fsm_state),
  .data  (rx_data_o),
  .rdy   (rx_ready_o),
  .err   (rx_error_o)
);

// File: tb/test_mid_uart_rx.sv
`timescale 1ns/1ps
module test_mid_uart_rx;
  localparam int OVS = 8;

  logic       clk;
  logic       rst_n;
  logic       rx;
  logic       tick;
  logic [7:0] data;
  logic       rdy;
  logic       err;

  int total = 0;
  int bad   = 0;
  int div   = 1;
  int rdy_cnt = 0;
  int err_cnt = 0;
  logic [7:0] cap [0:1023];
  logic       done = 1'b0;

  mid_uart_rx #(.DATA_W(8), .OVS(OVS)) i_mid_uart_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_i       (rx),
    .os_tick_i  (tick),
    .rx_data_o  (data),
    .rx_ready_o (rdy),
    .rx_error_o (err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (div == 1) tick <= 1'b1;
    else          tick <= ~tick;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (rdy) begin
        cap[rdy_cnt % 1024] = data;
        rdy_cnt = rdy_cnt + 1;
      end
      if (err) err_cnt = err_cnt + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total = total + 1;
    if (act != exp) begin
      bad = bad + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input logic stop_v);
    int bc;
    bc = OVS * div;
    rx = 1'b0;
    repeat (bc) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx = b[i];
      repeat (bc) @(negedge clk);
    end
    rx = stop_v;
    repeat (bc) @(negedge clk);
  endtask

  task automatic good_frame(input logic [7:0] b, input string req);
    int r0;
    int e0;
    r0 = rdy_cnt;
    e0 = err_cnt;
    send(b, 1'b1);
    idle(8);
    check(req, rdy_cnt - r0, 1);
    check(req, err_cnt - e0, 0);
    check(req, data, b);
  endtask

  initial begin
    int r0;
    int e0;
    logic [7:0] lastb;
    rx    = 1'b1;
    tick  = 1'b1;
    rst_n = 1'b0;
    idle(5);
    // R1: values during reset
    check("R1 data", data, 0);
    check("R1 rdy", rdy, 0);
    check("R1 err", err, 0);
    rst_n = 1'b1;
    idle(10);
    check("R1 data after", data, 0);
    check("R1 pulses after", rdy_cnt + err_cnt, 0);

    // R4 R5: every byte value, one tick per clock
    for (int b = 0; b < 256; b++) good_frame(8'(b), "R4 R5 sweep");

    // R9: back-to-back frames
    r0 = rdy_cnt;
    for (int k = 0; k < 6; k++) send(8'(8'hC3 ^ (k * 29)), 1'b1);
    idle(8);
    check("R9 count", rdy_cnt - r0, 6);
    for (int k = 0; k < 6; k++) check("R9 byte", cap[(r0 + k) % 1024], 8'(8'hC3 ^ (k * 29)));
    lastb = 8'(8'hC3 ^ (5 * 29));

    // R6 R7 R2: stop bit low, line then held low
    r0 = rdy_cnt;
    e0 = err_cnt;
    send(8'h5A, 1'b0);
    idle(6);
    check("R6 err", err_cnt - e0, 1);
    check("R6 no rdy", rdy_cnt - r0, 0);
    check("R7 data kept", data, lastb);
    idle(OVS * 20);
    check("R2 held low no event", rdy_cnt - r0 + err_cnt - e0 - 1, 0);
    rx = 1'b1;
    idle(OVS * 4);
    check("R2 rise no event", rdy_cnt - r0 + err_cnt - e0 - 1, 0);
    check("R7 data kept idle", data, lastb);

    // R3: short start pulse
    r0 = rdy_cnt;
    e0 = err_cnt;
    rx = 1'b0;
    idle(2);
    rx = 1'b1;
    idle(OVS * 3);
    check("R3 glitch err", err_cnt - e0, 1);
    check("R3 glitch no rdy", rdy_cnt - r0, 0);
    check("R7 data after glitch", data, lastb);
    good_frame(8'hA5, "R3 recover");

    // R8: tick on every other clock
    div = 2;
    idle(4);
    for (int k = 0; k < 32; k++) good_frame(8'((k * 37 + 11) % 256), "R8 half tick");
    r0 = rdy_cnt;
    for (int k = 0; k < 4; k++) send(8'(k * 64 + 7), 1'b1);
    idle(16);
    check("R8 R9 count", rdy_cnt - r0, 4);
    for (int k = 0; k < 4; k++) check("R8 R9 byte", cap[(r0 + k) % 1024], k * 64 + 7);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total = total + 1;
      bad   = bad + 1;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule